// File: doc/BRIEF.md
# Randomly Sampled Cache Miss Recorder

This block watches the miss traffic of several cache request ports and, from time to time, picks one miss and records it for software to read. A recorded entry holds the instruction address of the missing access, the data address when the access was a load or store, the port it came from, whether it also missed the translation buffer and where that translation was found, and the miss latency in cycles. While one miss is being timed, the recorder is busy and takes no other miss.

A recorder that always took the next miss after going idle would never see the misses that arrive while its latency counter runs. To avoid this bias, a free-running pseudo-random shift register picks which port is eligible each cycle and whether a miss that starts there is taken at all. About one miss in eight on the eligible port is tracked. Software sets a minimum latency. A timed miss below that minimum is dropped and the recorder re-arms. A miss at or above it updates the log and raises a one-cycle event pulse that an event counter can count.

Top module: `miss_sampler`

## Requirements
- R1: After reset, log_valid_o and sample_evt_o are 0 and every log output is 0.
- R2: The random source is a 16-bit shift register loaded with the SEED parameter during reset (default 16'hACE1). It advances on every clock edge as s <= {s[14:0], s[15]^s[13]^s[12]^s[10]}. The eligible port is s[1:0]. A miss is granted when s[4:2] == 3'b000.
- R3: While idle, a miss start is taken only when it is on the eligible port and the grant holds in that same cycle. Its instruction address, tag, port and translation-miss flag are then stored. Starts on any other port, or without the grant, change nothing.
- R4: For a miss with its data flag set, the data address is logged. For a miss with the flag clear, log_daddr_o is written as 0.
- R5: The logged latency equals the number of cycles from the start cycle to the completion cycle, so a completion in the cycle right after the start gives 1.
- R6: A completion counts only when it arrives on the tracked port with a tag equal to the stored tag. Any other completion is ignored.
- R7: From the taken start up to and including its completion cycle, every new miss start is ignored.
- R8: A completion with latency >= lat_min_i updates the log and drives sample_evt_o high for exactly the following cycle. A completion with latency below lat_min_i leaves the log unchanged, gives no pulse and re-arms the recorder.
- R9: The latency counter saturates at 2^LAT_W-1 (255 by default) and does not wrap.
- R10: log_tlb_o gives the translation-miss flag of the recorded miss. log_tlb_src_o gives the per-port resolution code presented with the completion when that flag is set, and 0 when it is clear.
- R11: log_valid_o goes to 1 with the first logged sample and stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lat_min_i | input | LAT_W | Minimum latency that a sample must reach to be logged |
| miss_start_i | input | NUM_PORTS | Per-port miss start strobe |
| miss_tag_i | input | NUM_PORTS*TAG_W | Per-port tag of the starting miss |
| miss_iaddr_i | input | NUM_PORTS*IA_W | Per-port instruction address |
| miss_daddr_i | input | NUM_PORTS*DA_W | Per-port data address |
| miss_is_data_i | input | NUM_PORTS | Per-port flag: the miss is a data access |
| miss_tlb_i | input | NUM_PORTS | Per-port flag: the access also missed the translation buffer |
| done_i | input | NUM_PORTS | Per-port miss completion strobe |
| done_tag_i | input | NUM_PORTS*TAG_W | Per-port tag of the completing miss |
| done_tlb_src_i | input | NUM_PORTS*SRC_W | Per-port code giving where the translation was resolved |
| log_iaddr_o | output | IA_W | Logged instruction address |
| log_daddr_o | output | DA_W | Logged data address |
| log_lat_o | output | LAT_W | Logged latency |
| log_port_o | output | PSEL_W | Logged port index |
| log_is_data_o | output | 1 | Logged data-access flag |
| log_tlb_o | output | 1 | Logged translation-miss flag |
| log_tlb_src_o | output | SRC_W | Logged translation resolution code |
| log_valid_o | output | 1 | The log holds at least one sample |
| sample_evt_o | output | 1 | One-cycle pulse per logged sample |

## Verification
The bench keeps its own model of the random register and uses it to place starts on cycles where the grant holds, and also on cycles where only the port matches or only the grant holds. A design that took ungranted starts, or sampled the register one cycle off, would log an address the bench never meant to be recorded. Latencies are checked at 1, at the threshold, one below it and past saturation. A counter that wrapped, or that was off by one cycle, would show the wrong value or raise or drop a pulse at the boundary. Mismatched-tag and wrong-port completions, and a burst of starts on every port while busy, check that the first tracked miss stays the one that gets logged.

// File: rtl/ms_pkg.sv
package ms_pkg;
  typedef enum logic {ST_IDLE, ST_BUSY} ms_state_e;

  localparam int unsigned LFSR_W = 16;

  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/ms_lfsr.sv
module ms_lfsr
  import ms_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [LFSR_W-1:0] state_o
);
  logic [LFSR_W-1:0] s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s_q <= SEED;
    else         s_q <= lfsr_next(s_q);
  end

  assign state_o = s_q;

  // R2
  lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) s_q != '0)
    else $error("lfsr reached all-zero");
endmodule

// File: rtl/ms_port_mux.sv
module ms_port_mux #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned W         = 8,
  localparam int unsigned SEL_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic [NUM_PORTS*W-1:0] data_i,
  input  logic [SEL_W-1:0]       sel_i,
  output logic [W-1:0]           data_o
);
  always_comb begin
    data_o = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (sel_i == SEL_W'(p)) data_o = data_i[p*W +: W];
    end
  end
endmodule

// File: rtl/ms_lat_counter.sv
module ms_lat_counter #(
  parameter int unsigned LAT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [LAT_W-1:0] cnt_o,
  output logic [LAT_W-1:0] cnt_inc_o
);
  localparam logic [LAT_W-1:0] MAXV = '1;
  logic [LAT_W-1:0] cnt_q;

  assign cnt_inc_o = (cnt_q == MAXV) ? MAXV : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_inc_o;
  end

  assign cnt_o = cnt_q;

  // R9
  lat_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && cnt_q == MAXV) |=> (cnt_q == MAXV))
    else $error("latency counter wrapped");

  // R9
  lat_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && cnt_q != MAXV) |=> (cnt_q == $past(cnt_q) + 1'b1))
    else $error("latency counter skipped");
endmodule

// File: rtl/miss_sampler.sv
module miss_sampler
  import ms_pkg::*;
#(
  parameter int unsigned       NUM_PORTS = 4,
  parameter int unsigned       TAG_W     = 4,
  parameter int unsigned       IA_W      = 16,
  parameter int unsigned       DA_W      = 16,
  parameter int unsigned       LAT_W     = 8,
  parameter int unsigned       SRC_W     = 2,
  parameter logic [LFSR_W-1:0] SEED      = 16'hACE1,
  localparam int unsigned      PSEL_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [LAT_W-1:0]          lat_min_i,
  input  logic [NUM_PORTS-1:0]      miss_start_i,
  input  logic [NUM_PORTS*TAG_W-1:0] miss_tag_i,
  input  logic [NUM_PORTS*IA_W-1:0] miss_iaddr_i,
  input  logic [NUM_PORTS*DA_W-1:0] miss_daddr_i,
  input  logic [NUM_PORTS-1:0]      miss_is_data_i,
  input  logic [NUM_PORTS-1:0]      miss_tlb_i,
  input  logic [NUM_PORTS-1:0]      done_i,
  input  logic [NUM_PORTS*TAG_W-1:0] done_tag_i,
  input  logic [NUM_PORTS*SRC_W-1:0] done_tlb_src_i,
  output logic [IA_W-1:0]           log_iaddr_o,
  output logic [DA_W-1:0]           log_daddr_o,
  output logic [LAT_W-1:0]          log_lat_o,
  output logic [PSEL_W-1:0]         log_port_o,
  output logic                      log_is_data_o,
  output logic                      log_tlb_o,
  output logic [SRC_W-1:0]          log_tlb_src_o,
  output logic                      log_valid_o,
  output logic                      sample_evt_o
);
  localparam int unsigned SB_W = 1 + TAG_W + IA_W + DA_W + 2;
  localparam int unsigned DB_W = 1 + TAG_W + SRC_W;

  // random source: port pick in low bits, 3-bit grant field above it
  logic [LFSR_W-1:0] rnd;
  logic [PSEL_W-1:0] elig_port;
  logic              grant;

  ms_lfsr #(.SEED(SEED)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .state_o(rnd)
  );

  assign elig_port = rnd[PSEL_W-1:0];
  assign grant     = (rnd[PSEL_W+2:PSEL_W] == 3'b000);

  // per-port bundles
  logic [NUM_PORTS*SB_W-1:0] sb_all;
  logic [NUM_PORTS*DB_W-1:0] db_all;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_bundle
    assign sb_all[p*SB_W +: SB_W] = {miss_start_i[p],
                                     miss_tag_i[p*TAG_W +: TAG_W],
                                     miss_iaddr_i[p*IA_W +: IA_W],
                                     miss_daddr_i[p*DA_W +: DA_W],
                                     miss_is_data_i[p],
                                     miss_tlb_i[p]};
    assign db_all[p*DB_W +: DB_W] = {done_i[p],
                                     done_tag_i[p*TAG_W +: TAG_W],
                                     done_tlb_src_i[p*SRC_W +: SRC_W]};
  end

  logic [SB_W-1:0] sb_sel;
  logic [DB_W-1:0] db_sel;
  logic [PSEL_W-1:0] trk_port_q;

  ms_port_mux #(.NUM_PORTS(NUM_PORTS), .W(SB_W)) u_start_mux (
    .data_i(sb_all),
    .sel_i (elig_port),
    .data_o(sb_sel)
  );

  ms_port_mux #(.NUM_PORTS(NUM_PORTS), .W(DB_W)) u_done_mux (
    .data_i(db_all),
    .sel_i (trk_port_q),
    .data_o(db_sel)
  );

  logic             s_start, s_isd, s_tlb;
  logic [TAG_W-1:0] s_tag;
  logic [IA_W-1:0]  s_ia;
  logic [DA_W-1:0]  s_da;
  logic             d_done;
  logic [TAG_W-1:0] d_tag;
  logic [SRC_W-1:0] d_src;

  assign {s_start, s_tag, s_ia, s_da, s_isd, s_tlb} = sb_sel;
  assign {d_done, d_tag, d_src}                     = db_sel;

  // control
  ms_state_e        state_q;
  logic [TAG_W-1:0] tag_q;
  logic [IA_W-1:0]  ia_q;
  logic [DA_W-1:0]  da_q;
  logic             isd_q, tlb_q;
  logic             take, hit, keep;
  logic [LAT_W-1:0] lat_cnt, lat_fin;

  assign take = (state_q == ST_IDLE) && s_start && grant;
  assign hit  = (state_q == ST_BUSY) && d_done && (d_tag == tag_q);
  assign keep = hit && (lat_fin >= lat_min_i);

  ms_lat_counter #(.LAT_W(LAT_W)) u_lat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (take),
    .en_i     (state_q == ST_BUSY),
    .cnt_o    (lat_cnt),
    .cnt_inc_o(lat_fin)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      trk_port_q <= '0;
      tag_q      <= '0;
      ia_q       <= '0;
      da_q       <= '0;
      isd_q      <= 1'b0;
      tlb_q      <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (take) begin
          state_q    <= ST_BUSY;
          trk_port_q <= elig_port;
          tag_q      <= s_tag;
          ia_q       <= s_ia;
          da_q       <= s_isd ? s_da : '0;
          isd_q      <= s_isd;
          tlb_q      <= s_tlb;
        end
        ST_BUSY: if (hit) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // log registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      log_iaddr_o   <= '0;
      log_daddr_o   <= '0;
      log_lat_o     <= '0;
      log_port_o    <= '0;
      log_is_data_o <= 1'b0;
      log_tlb_o     <= 1'b0;
      log_tlb_src_o <= '0;
      log_valid_o   <= 1'b0;
      sample_evt_o  <= 1'b0;
    end else begin
      sample_evt_o <= keep;
      if (keep) begin
        log_iaddr_o   <= ia_q;
        log_daddr_o   <= da_q;
        log_lat_o     <= lat_fin;
        log_port_o    <= trk_port_q;
        log_is_data_o <= isd_q;
        log_tlb_o     <= tlb_q;
        log_tlb_src_o <= tlb_q ? d_src : '0;
        log_valid_o   <= 1'b1;
      end
    end
  end

  // R7
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BUSY) |=> ($stable(ia_q) && $stable(tag_q) && $stable(trk_port_q)))
    else $error("tracked miss replaced while busy");

  // R8
  evt_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_evt_o |=> !sample_evt_o)
    else $error("event longer than one cycle");

  // R8
  log_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_evt_o |-> ($stable(log_iaddr_o) && $stable(log_lat_o)))
    else $error("log changed without event");

  // R8
  evt_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_evt_o |-> (log_lat_o >= $past(lat_min_i)))
    else $error("sample below threshold logged");

  // R11
  valid_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    log_valid_o |=> log_valid_o)
    else $error("valid dropped");

  // R3
  take_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !take) |=> (state_q == ST_IDLE))
    else $error("left idle without a granted start");
endmodule

// File: tb/sim_miss_sampler.sv
module sim_miss_sampler;
  localparam int NP = 4, TW = 4, IW = 16, DW = 16, LW = 8, SW = 2;
  localparam logic [15:0] SEED = 16'hACE1;

  typedef struct packed {
    logic [1:0]  port;
    logic [3:0]  tag;
    logic [15:0] ia;
    logic [15:0] da;
    logic        isd;
    logic        tlb;
    logic [1:0]  src;
    logic [9:0]  dly;
    logic [7:0]  thr;
    logic        exp;
  } vec_t;

  localparam vec_t TBL [0:5] = '{
    '{2'd0, 4'h3, 16'h1000, 16'h2000, 1'b1, 1'b0, 2'd0, 10'd4, 8'd0, 1'b1},
    '{2'd2, 4'h5, 16'h1111, 16'h3333, 1'b0, 1'b1, 2'd2, 10'd7, 8'd6, 1'b1},
    '{2'd1, 4'h9, 16'h2222, 16'h4444, 1'b1, 1'b0, 2'd1, 10'd3, 8'd8, 1'b0},
    '{2'd3, 4'hF, 16'h3333, 16'h5555, 1'b1, 1'b1, 2'd3, 10'd1, 8'd1, 1'b1},
    '{2'd0, 4'h0, 16'h4444, 16'h6666, 1'b0, 1'b0, 2'd1, 10'd9, 8'd9, 1'b1},
    '{2'd2, 4'h1, 16'h5555, 16'h7777, 1'b1, 1'b1, 2'd2, 10'd8, 8'd9, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [LW-1:0]    lat_min;
  logic [NP-1:0]    m_start, m_isd, m_tlb, d_done;
  logic [NP*TW-1:0] m_tag, d_tag;
  logic [NP*IW-1:0] m_ia;
  logic [NP*DW-1:0] m_da;
  logic [NP*SW-1:0] d_src;
  logic [IW-1:0] o_ia;
  logic [DW-1:0] o_da;
  logic [LW-1:0] o_lat;
  logic [1:0]    o_port, o_src;
  logic          o_isd, o_tlb, o_valid, o_evt;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [15:0] mdl;

  always #4 clk = ~clk;

  miss_sampler #(.NUM_PORTS(NP), .TAG_W(TW), .IA_W(IW), .DA_W(DW), .LAT_W(LW),
                 .SRC_W(SW), .SEED(SEED)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .lat_min_i(lat_min),
    .miss_start_i(m_start), .miss_tag_i(m_tag), .miss_iaddr_i(m_ia),
    .miss_daddr_i(m_da), .miss_is_data_i(m_isd), .miss_tlb_i(m_tlb),
    .done_i(d_done), .done_tag_i(d_tag), .done_tlb_src_i(d_src),
    .log_iaddr_o(o_ia), .log_daddr_o(o_da), .log_lat_o(o_lat), .log_port_o(o_port),
    .log_is_data_o(o_isd), .log_tlb_o(o_tlb), .log_tlb_src_o(o_src),
    .log_valid_o(o_valid), .sample_evt_o(o_evt));

  // R2 model of the random register, written from the requirement
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mdl <= SEED;
    else        mdl <= {mdl[14:0], mdl[15] ^ mdl[13] ^ mdl[12] ^ mdl[10]};
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    m_start = '0; m_isd = '0; m_tlb = '0; d_done = '0;
    m_tag = '0; d_tag = '0; m_ia = '0; m_da = '0; d_src = '0;
  endtask

  task automatic put_start(input int p, input logic [3:0] tg, input logic [15:0] ia,
                           input logic [15:0] da, input logic isd, input logic tlb);
    m_start[p] = 1'b1; m_tag[p*TW +: TW] = tg; m_ia[p*IW +: IW] = ia;
    m_da[p*DW +: DW] = da; m_isd[p] = isd; m_tlb[p] = tlb;
  endtask

  task automatic put_done(input int p, input logic [3:0] tg, input logic [1:0] src);
    d_done[p] = 1'b1; d_tag[p*TW +: TW] = tg; d_src[p*SW +: SW] = src;
  endtask

  task automatic wait_grant(input int p);
    @(negedge clk);
    while (!(mdl[1:0] == 2'(p) && mdl[4:2] == 3'b000)) @(negedge clk);
  endtask

  // mode 0 plain, 1 start burst while busy (R7), 2 decoy completions at cycle 2 (R6)
  task automatic run_miss(input int p, input logic [3:0] tg, input logic [15:0] ia,
                          input logic [15:0] da, input logic isd, input logic tlb,
                          input logic [1:0] src, input int dly, input int mode);
    wait_grant(p);
    put_start(p, tg, ia, da, isd, tlb);
    @(negedge clk);
    idle_inputs();
    for (int k = 1; k < dly; k++) begin
      if (mode == 1) for (int q = 0; q < NP; q++) put_start(q, tg, 16'hBBBB, 16'hBBBB, 1'b1, 1'b1);
      if (mode == 2 && k == 2) begin
        put_done(p, tg ^ 4'h1, 2'd0);
        put_done((p + 1) % NP, tg, 2'd0);
      end
      @(negedge clk);
      if (mode == 2 && k == 2) chk(o_evt == 1'b0, "R6 decoy completion", o_evt, 0);
      idle_inputs();
    end
    if (mode == 1) for (int q = 0; q < NP; q++) put_start(q, tg, 16'hBBBB, 16'hBBBB, 1'b1, 1'b1);
    put_done(p, tg, src);
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] prev_ia;
    logic [7:0]  prev_lat;
    idle_inputs();
    lat_min = '0;
    repeat (3) @(negedge clk);
    // R1
    chk(o_valid == 0, "R1 valid", o_valid, 0);
    chk(o_evt == 0, "R1 event", o_evt, 0);
    chk(o_ia == 0 && o_da == 0 && o_lat == 0 && o_src == 0, "R1 log", o_ia, 0);
    rst_n = 1'b1;

    // table of vectors
    for (int i = 0; i < 6; i++) begin
      vec_t v;
      v = TBL[i];
      prev_ia = o_ia; prev_lat = o_lat;
      lat_min = v.thr;
      run_miss(v.port, v.tag, v.ia, v.da, v.isd, v.tlb, v.src, int'(v.dly), 0);
      if (v.exp) begin
        chk(o_evt == 1, "R8 event on kept sample", o_evt, 1);
        chk(o_ia == v.ia, "R3 iaddr", o_ia, v.ia);
        chk(o_port == v.port, "R3 port", o_port, v.port);
        chk(o_da == (v.isd ? v.da : 16'h0), "R4 daddr", o_da, v.isd ? v.da : 16'h0);
        chk(o_isd == v.isd, "R4 data flag", o_isd, v.isd);
        chk(o_lat == 8'(v.dly), "R5 latency", o_lat, v.dly);
        chk(o_tlb == v.tlb, "R10 tlb flag", o_tlb, v.tlb);
        chk(o_src == (v.tlb ? v.src : 2'd0), "R10 tlb source", o_src, v.tlb ? v.src : 2'd0);
        chk(o_valid == 1, "R11 valid", o_valid, 1);
      end else begin
        chk(o_evt == 0, "R8 no event below threshold", o_evt, 0);
        chk(o_ia == prev_ia && o_lat == prev_lat, "R8 log unchanged", o_ia, prev_ia);
      end
      @(negedge clk);
      chk(o_evt == 0, "R8 single-cycle pulse", o_evt, 0);
    end

    // R3: start on the eligible port without grant
    lat_min = 8'd0;
    prev_ia = o_ia;
    @(negedge clk);
    while (!(mdl[1:0] == 2'd1 && mdl[4:2] != 3'b000)) @(negedge clk);
    put_start(1, 4'h6, 16'hDEAD, 16'h0, 1'b0, 1'b0);
    @(negedge clk);
    idle_inputs();
    put_done(1, 4'h6, 2'd0);
    @(negedge clk);
    idle_inputs();
    chk(o_evt == 0 && o_ia == prev_ia, "R3 ungranted start ignored", o_ia, prev_ia);

    // R3: granted cycle but start on a non-eligible port
    @(negedge clk);
    while (!(mdl[4:2] == 3'b000)) @(negedge clk);
    put_start(int'(mdl[1:0] ^ 2'd2), 4'h7, 16'hBEEF, 16'h0, 1'b0, 1'b0);
    @(negedge clk);
    idle_inputs();
    for (int q = 0; q < NP; q++) put_done(q, 4'h7, 2'd0);
    @(negedge clk);
    idle_inputs();
    chk(o_evt == 0 && o_ia == prev_ia, "R3 wrong-port start ignored", o_ia, prev_ia);

    // R6: decoys then the real completion
    run_miss(3, 4'hA, 16'h6006, 16'h0, 1'b0, 1'b0, 2'd0, 5, 2);
    chk(o_evt == 1 && o_ia == 16'h6006, "R6 real completion", o_ia, 16'h6006);
    chk(o_lat == 8'd5, "R6 latency after decoy", o_lat, 5);

    // R7: starts on every port while busy
    run_miss(0, 4'h2, 16'hAAAA, 16'h1234, 1'b1, 1'b0, 2'd0, 6, 1);
    chk(o_ia == 16'hAAAA && o_da == 16'h1234, "R7 busy starts ignored", o_ia, 16'hAAAA);
    chk(o_lat == 8'd6, "R7 latency", o_lat, 6);
    @(negedge clk);
    idle_inputs();
    chk(o_evt == 0, "R7 no second sample", o_evt, 0);

    // R9: saturation
    run_miss(2, 4'hC, 16'h7007, 16'h0, 1'b0, 1'b1, 2'd3, 300, 0);
    chk(o_lat == 8'hFF, "R9 saturated latency", o_lat, 8'hFF);
    chk(o_src == 2'd3, "R10 source on long miss", o_src, 3);

    // R9/R8: saturated value compared against a high threshold
    lat_min = 8'hFF;
    run_miss(1, 4'h4, 16'h8008, 16'h0, 1'b0, 1'b0, 2'd0, 280, 0);
    chk(o_evt == 1 && o_lat == 8'hFF, "R9 saturated meets max threshold", o_lat, 8'hFF);
    chk(o_valid == 1, "R11 valid held", o_valid, 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule